// File: doc/BRIEF.md
# Interrupt Request Gateway with Event Queue

This block sits between one raw interrupt line and a prioritising interrupt core. It turns activity on the line into at most one outstanding request at a time, then waits for the core to claim that request and for software to signal completion. After completion it releases the source again. The mode input selects how the line is interpreted. In level mode the line being high is the request. In edge mode only a low-to-high transition counts, and the transition is found by comparing the line with its value one clock earlier.

In edge mode, rising edges that arrive while a request is outstanding are not lost. They are counted in a saturating event counter, up to a parameter limit. Edges beyond that limit are dropped without notice. When completion arrives and the counter is nonzero, the gateway raises its request again on the next clock without waiting for a new edge. The counter is reduced by one at the claim of such a replayed request. The core sees a single pending flag and the current queue depth.

Top module: `irq_gateway`

## Requirements
- R1: While the active-low asynchronous reset is low, `req_pending` is 0 and `evt_count` is 0, and the gateway is free (no outstanding request).
- R2: With `edge_mode`=0 and the gateway free, `src_in` high at a clock edge sets `req_pending` to 1 after that edge.
- R3: With `edge_mode`=0, activity on `src_in` while a request is outstanding is ignored: `evt_count` stays 0 and no extra request results.
- R4: With `edge_mode`=1 and the gateway free, a clock edge where `src_in` is 1 and was 0 at the previous edge sets `req_pending`. A line held high does not trigger again.
- R5: With `edge_mode`=1, each rising edge seen while a request is outstanding (pending or claimed) increments `evt_count` by one.
- R6: `evt_count` never exceeds the parameter `MAX_QUEUED` (default 8, may be 0). A rising edge that finds the count at the limit is dropped.
- R7: `claim_pulse` while `req_pending`=1 clears `req_pending` after that edge. `claim_pulse` while `req_pending`=0 has no effect.
- R8: Once a request is raised, `req_pending` stays 0 after its claim until a completion is accepted.
- R9: A completion accepted with `evt_count`>0 sets `req_pending` after that edge and leaves the count unchanged. The claim of that replayed request lowers `evt_count` by one in the same edge.
- R10: A completion accepted with `evt_count`=0 frees the gateway. If a trigger (level high, or rising edge) is present at that same edge, a fresh request is raised instead.
- R11: `done_pulse` is accepted only when a request has been claimed and not yet completed. At any other time it has no effect on `req_pending` or `evt_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 1 | Raw interrupt line from the source |
| edge_mode | input | 1 | 1 = rising-edge trigger, 0 = level trigger |
| claim_pulse | input | 1 | Core claims the pending request (one cycle) |
| done_pulse | input | 1 | Completion notification (one cycle) |
| req_pending | output | 1 | Request presented to the prioritising core |
| evt_count | output | CNT_W | Number of queued edge events |

## Verification
Every state element is a single register stage. A change on `src_in`, `claim_pulse` or `done_pulse` that is present at a rising edge therefore appears on `req_pending` and `evt_count` right after that edge. A rising edge on the line is judged against the line value held one edge earlier. The bench drives inputs on the falling edge and advances its own reference model at the rising edge. It then compares both outputs at the next falling edge, so every check lands exactly one clock after the stimulus it depends on. Directed sequences cover saturation, replay, ignored pulses and retrigger at completion. Seeded random traffic in both modes follows them.

// File: rtl/gw_pkg.sv
package gw_pkg;

  // width of the queued-event counter; at least one bit even for a zero limit
  function automatic int cnt_width(input int max_q);
    return (max_q > 0) ? $clog2(max_q + 1) : 1;
  endfunction

  // rising edge: line high now, low at the previous clock
  function automatic logic rise_seen(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // trigger condition for the selected mode
  function automatic logic trigger_of(input logic edge_sel, input logic cur,
                                      input logic prev);
    return edge_sel ? rise_seen(cur, prev) : cur;
  endfunction

endpackage

// File: rtl/gw_edge_detect.sv
module gw_edge_detect
  import gw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic edge_mode,
  output logic trig
);

  logic src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_in;
  end

  assign trig = trigger_of(edge_mode, src_in, src_q);

  // R4
  edge_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && trig) |=> $past(src_in) && !$past(src_q));

endmodule

// File: rtl/gw_event_queue.sv
module gw_event_queue
  import gw_pkg::*;
#(
  parameter int MAX_QUEUED = 8,
  parameter int CNT_W      = cnt_width(MAX_QUEUED)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_QUEUED);

  logic accept_inc;

  assign accept_inc = inc && (count != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (accept_inc && !dec) begin
      count <= count + 1'b1;
    end else if (dec && !accept_inc) begin
      count <= count - 1'b1;
    end
  end

  // R6
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && count != LIMIT) |=> count == $past(count) + 1'b1);

  // R9
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/gw_handshake.sv
module gw_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic claim_pulse,
  input  logic done_pulse,
  input  logic queued_nz,
  output logic pend,
  output logic busy,
  output logic replay,
  output logic claim_ok,
  output logic cmpl_ok
);

  assign claim_ok = claim_pulse && pend;
  assign cmpl_ok  = done_pulse && busy && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      busy   <= 1'b0;
      replay <= 1'b0;
    end else if (claim_ok) begin
      pend   <= 1'b0;
      replay <= 1'b0;
    end else if (!busy && trig) begin
      pend   <= 1'b1;
      busy   <= 1'b1;
      replay <= 1'b0;
    end else if (cmpl_ok) begin
      if (queued_nz) begin
        pend   <= 1'b1;
        replay <= 1'b1;
      end else if (trig) begin
        pend   <= 1'b1;
        replay <= 1'b0;
      end else begin
        busy   <= 1'b0;
      end
    end
  end

  // R7
  claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_ok |=> !pend);

  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend && !cmpl_ok) |=> !pend);

  // R9
  replay_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_ok && queued_nz) |=> pend && replay);

  // R11
  pend_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
  import gw_pkg::*;
#(
  parameter int MAX_QUEUED = 8,
  parameter int CNT_W      = cnt_width(MAX_QUEUED)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_in,
  input  logic             edge_mode,
  input  logic             claim_pulse,
  input  logic             done_pulse,
  output logic             req_pending,
  output logic [CNT_W-1:0] evt_count
);

  logic trig_w;
  logic busy_w;
  logic replay_w;
  logic claim_ok_w;
  logic cmpl_ok_w;
  logic queued_nz_w;
  logic fresh_at_done_w;
  logic q_inc_w;
  logic q_dec_w;

  gw_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .edge_mode (edge_mode),
    .trig      (trig_w)
  );

  assign queued_nz_w     = (evt_count != '0);
  // a trigger that meets a completion with an empty queue becomes a fresh request
  assign fresh_at_done_w = cmpl_ok_w && !queued_nz_w;
  assign q_inc_w         = edge_mode && trig_w && busy_w && !fresh_at_done_w;
  assign q_dec_w         = claim_ok_w && replay_w;

  gw_event_queue #(
    .MAX_QUEUED (MAX_QUEUED),
    .CNT_W      (CNT_W)
  ) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (q_inc_w),
    .dec   (q_dec_w),
    .count (evt_count)
  );

  gw_handshake u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig_w),
    .claim_pulse (claim_pulse),
    .done_pulse  (done_pulse),
    .queued_nz   (queued_nz_w),
    .pend        (req_pending),
    .busy        (busy_w),
    .replay      (replay_w),
    .claim_ok    (claim_ok_w),
    .cmpl_ok     (cmpl_ok_w)
  );

  // R3
  level_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && evt_count == '0) |=> evt_count == '0);

  // R2
  level_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && src_in && !busy_w) |=> req_pending);

endmodule

// File: tb/sim_irq_gateway.sv
module sim_irq_gateway;
  import gw_pkg::*;

  localparam int QMAX = 3;
  localparam int CW   = cnt_width(QMAX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_in = 1'b0;
  logic edge_mode = 1'b0;
  logic claim_pulse = 1'b0;
  logic done_pulse = 1'b0;
  logic req_pending;
  logic [CW-1:0] evt_count;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state
  bit m_prev = 1'b0;
  bit m_busy = 1'b0;
  bit m_pend = 1'b0;
  bit m_rep  = 1'b0;
  int m_cnt  = 0;

  always #2 clk = ~clk;

  irq_gateway #(.MAX_QUEUED(QMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_mode),
    .claim_pulse(claim_pulse), .done_pulse(done_pulse),
    .req_pending(req_pending), .evt_count(evt_count)
  );

  function automatic bit room_left(input int c);
    return c < QMAX;
  endfunction

  task automatic model_step();
    bit t;
    int c0;
    c0 = m_cnt;
    t  = edge_mode ? (src_in && !m_prev) : src_in;
    if (!m_busy) begin
      if (t) begin m_busy = 1; m_pend = 1; m_rep = 0; end
    end else if (m_pend) begin
      if (edge_mode && t && room_left(c0)) m_cnt++;
      if (claim_pulse) begin
        m_pend = 0;
        if (m_rep) begin m_cnt--; m_rep = 0; end
      end
    end else if (done_pulse) begin
      if (c0 > 0) begin
        m_pend = 1; m_rep = 1;
        if (edge_mode && t && room_left(c0)) m_cnt++;
      end else if (t) begin
        m_pend = 1; m_rep = 0;
      end else begin
        m_busy = 0;
      end
    end else if (edge_mode && t && room_left(c0)) begin
      m_cnt++;
    end
    m_prev = src_in;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    n_run++;
    if (req_pending !== m_pend || int'(evt_count) != m_cnt) begin
      n_fail++;
      $display("FAIL %s: pend=%0b count=%0d expected pend=%0b count=%0d",
               tag, req_pending, evt_count, m_pend, m_cnt);
    end
  endtask

  task automatic pulse_claim(input string tag);
    claim_pulse = 1; tick(); claim_pulse = 0; check(tag);
  endtask

  task automatic pulse_done(input string tag);
    done_pulse = 1; tick(); done_pulse = 0; check(tag);
  endtask

  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;

    // level mode
    edge_mode = 0;
    src_in = 1; tick(); check("R2 level raise");
    tick(); check("R2 level hold");
    pulse_claim("R7 claim clears");
    pulse_claim("R7 claim idle ignored");
    src_in = 0; tick(); src_in = 1; tick(); check("R3 level ignored while busy");
    check("R8 held off");
    pulse_done("R10 retrigger at completion");
    pulse_claim("R7 claim");
    src_in = 0;
    pulse_done("R10 freed");
    pulse_done("R11 done when free");
    tick(); check("R10 stays free");

    // edge mode
    edge_mode = 1;
    src_in = 1; tick(); check("R4 rise raises");
    pulse_claim("R7 claim edge");
    tick(); tick(); check("R4 held high no retrigger");
    for (int i = 0; i < 5; i++) begin
      src_in = 0; tick(); src_in = 1; tick();
      check("R5 queued edge");
    end
    check("R6 saturated");
    pulse_done("R9 replay raised");
    pulse_done("R11 done before claim");
    pulse_claim("R9 claim decrements");
    pulse_done("R9 replay again");
    pulse_claim("R9 claim decrements again");
    src_in = 0;
    pulse_done("R9 last replay");
    pulse_claim("R9 drained");
    pulse_done("R10 freed edge");

    // random traffic
    for (int blk = 0; blk < 8; blk++) begin
      edge_mode = blk[0];
      for (int i = 0; i < 2000; i++) begin
        src_in      = ($urandom % 3) == 0;
        claim_pulse = ($urandom % 5) == 0;
        done_pulse  = ($urandom % 6) == 0;
        tick();
        check("R5 R8 R9 R10 R11 random");
      end
    end
    claim_pulse = 0; done_pulse = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule